// File: doc/BRIEF.md
# Masked Write-One-to-Clear Interrupt Aggregator

This block collects interrupt sources into three independent groups and turns each group into one level request toward a processor. Every source input is a one-cycle (or longer) level that sets a sticky status bit. Software clears status bits by writing ones to them through a simple synchronous register port: a one-cycle access strobe with write flag, address and write data, with read data returned one cycle later.

The main group has a status register and a separate enable mask that a write replaces whole. The DMA group keeps 16 status bits and 16 enable bits in a single 32-bit word, status in the low half and enables in the high half. A write to that word only clears status; the enable half is loaded through its own offset. The bus-flag group has no mask at all: its request stays up while any flag is set. A source that fires in the same cycle as a clear of the same bit keeps the bit set. Each request output is registered and follows the enabled status one cycle later.

Top module: `irq_w1c_ctrl`

## Requirements
- R1: After reset every status bit, every mask bit and all three request outputs are 0, and reads of every register return 0.
- R2: A high source input sets its status bit at the next clock edge, and the bit stays set after the source drops.
- R3: A write to the main status offset 0xF000 clears every status bit whose write-data bit is 1 and leaves the other bits unchanged.
- R4: A write to the main mask offset 0xF010 replaces the whole main mask; a read of 0xF010 returns it.
- R5: main_irq_o is 1 exactly when (main status AND main mask) was nonzero at the previous clock edge.
- R6: A read of 0xE010 returns the DMA status in bits [15:0] and the DMA mask in bits [31:16]; a write to 0xE010 clears status bits set in write-data bits [15:0] and leaves the mask unchanged whatever bits [31:16] hold.
- R7: A write to offset 0xE020 replaces the DMA mask with write-data bits [31:16].
- R8: dma_irq_o is 1 exactly when (DMA status AND DMA mask) was nonzero at the previous clock edge.
- R9: A write to the bus-flag offset 0xF230 clears the flags set in the write data; flag_irq_o stays 1 until the whole flag register is 0.
- R10: When a source is high in the same cycle as a clear of its bit, the bit stays set.
- R11: Reads of unmapped offsets return 0 and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| host_req_i | input | 1 | Register access strobe, one cycle per access |
| host_we_i | input | 1 | 1 for write, 0 for read |
| host_addr_i | input | 16 | Register offset |
| host_wdata_i | input | 32 | Write data |
| host_rdata_o | output | 32 | Read data, valid the cycle after a read strobe |
| main_src_i | input | MAIN_W (32) | Main group sources |
| dma_src_i | input | 16 | DMA group sources |
| flag_src_i | input | FLAG_W (8) | Bus-flag group sources |
| main_irq_o | output | 1 | Main group request |
| dma_irq_o | output | 1 | DMA group request |
| flag_irq_o | output | 1 | Bus-flag group request |

## Verification
The hardest case to reach is a clear and a source pulse hitting the same status bit on the same clock edge, because the bench must align an external source with the write strobe exactly. The bench drives both from the same falling edge, with a write to 0xF000 and the matching source bit held for one cycle, then reads the status back to show the bit survived while a neighbouring bit cleared by the same write did not. A second subtle case is a DMA word write carrying ones in its high half; the bench reads the mask back afterwards to prove it was not touched.

// File: rtl/irq_w1c_pkg.sv
package irq_w1c_pkg;
  localparam int unsigned ADDR_W = 16;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned DMA_W  = 16;

  localparam logic [ADDR_W-1:0] OFS_MAIN_STAT = 16'hF000;
  localparam logic [ADDR_W-1:0] OFS_MAIN_MASK = 16'hF010;
  localparam logic [ADDR_W-1:0] OFS_DMA_WORD  = 16'hE010;
  localparam logic [ADDR_W-1:0] OFS_DMA_MASK  = 16'hE020;
  localparam logic [ADDR_W-1:0] OFS_FLAG      = 16'hF230;

  typedef struct packed {
    logic main_clr;
    logic main_mask;
    logic dma_clr;
    logic dma_mask;
    logic flag_clr;
  } wr_strb_t;
endpackage

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
  parameter int unsigned W        = 16,
  parameter bit          HAS_MASK = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] src_i,
  input  logic         clr_we_i,
  input  logic [W-1:0] clr_data_i,
  input  logic         mask_we_i,
  input  logic [W-1:0] mask_data_i,
  output logic [W-1:0] status_o,
  output logic [W-1:0] mask_o,
  output logic         irq_o
);
  logic [W-1:0] status_q;
  logic [W-1:0] clr_vec;
  logic [W-1:0] mask_q;
  logic         irq_q;

  assign clr_vec = clr_we_i ? clr_data_i : '0;

  // set wins over clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= '0;
    else         status_q <= (status_q & ~clr_vec) | src_i;
  end

  generate
    if (HAS_MASK) begin : g_mask
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)        mask_q <= '0;
        else if (mask_we_i) mask_q <= mask_data_i;
      end
    end else begin : g_nomask
      logic unused_mask;
      assign unused_mask = mask_we_i ^ (^mask_data_i);
      assign mask_q = '1;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |(status_q & mask_q);
  end

  assign status_o = status_q;
  assign mask_o   = mask_q;
  assign irq_o    = irq_q;

  p_set_sticky_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((status_q & $past(src_i)) == $past(src_i)));

  p_set_wins_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_we_i && |(src_i & clr_data_i)) |=> ((status_q & $past(src_i & clr_data_i)) == $past(src_i & clr_data_i)));

  p_w1c_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_we_i |=> ((status_q & $past(clr_data_i & ~src_i)) == '0));

  p_irq_low_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((status_q & mask_q) == '0) |=> !irq_o);

  p_irq_high_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((status_q & mask_q) != '0) |=> irq_o);
endmodule

// File: rtl/irq_host_port.sv
module irq_host_port
  import irq_w1c_pkg::*;
#(
  parameter int unsigned MAIN_W = 32,
  parameter int unsigned FLAG_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [MAIN_W-1:0] main_status_i,
  input  logic [MAIN_W-1:0] main_mask_i,
  input  logic [DMA_W-1:0]  dma_status_i,
  input  logic [DMA_W-1:0]  dma_mask_i,
  input  logic [FLAG_W-1:0] flag_status_i,
  output wr_strb_t          strb_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic              wr;
  logic              rd;
  logic [DATA_W-1:0] rd_mux;
  logic [DATA_W-1:0] rdata_q;

  assign wr = req_i && we_i;
  assign rd = req_i && !we_i;

  always_comb begin
    strb_o           = '0;
    strb_o.main_clr  = wr && (addr_i == OFS_MAIN_STAT);
    strb_o.main_mask = wr && (addr_i == OFS_MAIN_MASK);
    strb_o.dma_clr   = wr && (addr_i == OFS_DMA_WORD);
    strb_o.dma_mask  = wr && (addr_i == OFS_DMA_MASK);
    strb_o.flag_clr  = wr && (addr_i == OFS_FLAG);
  end

  always_comb begin
    rd_mux = '0;
    unique case (addr_i)
      OFS_MAIN_STAT: rd_mux[MAIN_W-1:0] = main_status_i;
      OFS_MAIN_MASK: rd_mux[MAIN_W-1:0] = main_mask_i;
      OFS_DMA_WORD:  rd_mux = {dma_mask_i, dma_status_i};
      OFS_DMA_MASK:  rd_mux = {dma_mask_i, {DMA_W{1'b0}}};
      OFS_FLAG:      rd_mux[FLAG_W-1:0] = flag_status_i;
      default:       rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  rdata_q <= '0;
    else if (rd)  rdata_q <= rd_mux;
  end

  assign rdata_o = rdata_q;

  p_one_strobe_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(strb_o));
endmodule

// File: rtl/irq_w1c_ctrl.sv
module irq_w1c_ctrl
  import irq_w1c_pkg::*;
#(
  parameter int unsigned MAIN_W = 32,
  parameter int unsigned FLAG_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              host_req_i,
  input  logic              host_we_i,
  input  logic [15:0]       host_addr_i,
  input  logic [31:0]       host_wdata_i,
  output logic [31:0]       host_rdata_o,
  input  logic [MAIN_W-1:0] main_src_i,
  input  logic [15:0]       dma_src_i,
  input  logic [FLAG_W-1:0] flag_src_i,
  output logic              main_irq_o,
  output logic              dma_irq_o,
  output logic              flag_irq_o
);
  wr_strb_t          strb;
  logic [MAIN_W-1:0] main_status, main_mask;
  logic [DMA_W-1:0]  dma_status, dma_mask;
  logic [FLAG_W-1:0] flag_status, flag_mask_unused;

  irq_host_port #(.MAIN_W(MAIN_W), .FLAG_W(FLAG_W)) u_port (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .req_i         (host_req_i),
    .we_i          (host_we_i),
    .addr_i        (host_addr_i),
    .main_status_i (main_status),
    .main_mask_i   (main_mask),
    .dma_status_i  (dma_status),
    .dma_mask_i    (dma_mask),
    .flag_status_i (flag_status),
    .strb_o        (strb),
    .rdata_o       (host_rdata_o)
  );

  irq_status_bank #(.W(MAIN_W), .HAS_MASK(1'b1)) u_main (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .src_i       (main_src_i),
    .clr_we_i    (strb.main_clr),
    .clr_data_i  (host_wdata_i[MAIN_W-1:0]),
    .mask_we_i   (strb.main_mask),
    .mask_data_i (host_wdata_i[MAIN_W-1:0]),
    .status_o    (main_status),
    .mask_o      (main_mask),
    .irq_o       (main_irq_o)
  );

  // clear uses the low half only; mask loads from the high half at its own offset
  irq_status_bank #(.W(DMA_W), .HAS_MASK(1'b1)) u_dma (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .src_i       (dma_src_i),
    .clr_we_i    (strb.dma_clr),
    .clr_data_i  (host_wdata_i[DMA_W-1:0]),
    .mask_we_i   (strb.dma_mask),
    .mask_data_i (host_wdata_i[DATA_W-1:DMA_W]),
    .status_o    (dma_status),
    .mask_o      (dma_mask),
    .irq_o       (dma_irq_o)
  );

  irq_status_bank #(.W(FLAG_W), .HAS_MASK(1'b0)) u_flag (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .src_i       (flag_src_i),
    .clr_we_i    (strb.flag_clr),
    .clr_data_i  (host_wdata_i[FLAG_W-1:0]),
    .mask_we_i   (1'b0),
    .mask_data_i ('0),
    .status_o    (flag_status),
    .mask_o      (flag_mask_unused),
    .irq_o       (flag_irq_o)
  );

  p_dma_mask_kept_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strb.dma_clr |=> $stable(dma_mask));

  p_main_mask_load_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strb.main_mask |=> (main_mask == $past(host_wdata_i[MAIN_W-1:0])));

  p_flag_irq_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_status != '0) |=> flag_irq_o);
endmodule

// File: tb/irq_w1c_ctrl_bench.sv
`timescale 1ns/1ps
module irq_w1c_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [15:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [31:0] msrc = '0;
  logic [15:0] dsrc = '0;
  logic [7:0]  fsrc = '0;
  logic        mirq, dirq, firq;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  irq_w1c_ctrl u_irq_w1c_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .host_req_i(req), .host_we_i(we),
    .host_addr_i(addr), .host_wdata_i(wdata), .host_rdata_o(rdata),
    .main_src_i(msrc), .dma_src_i(dsrc), .flag_src_i(fsrc),
    .main_irq_o(mirq), .dma_irq_o(dirq), .flag_irq_o(firq));

  task automatic chk(string req_id, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req_id, act, exp);
    end
  endtask

  task automatic wr(logic [15:0] a, logic [31:0] d);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); req = 0; we = 0; wdata = '0;
  endtask

  task automatic rd(logic [15:0] a, output logic [31:0] d);
    @(negedge clk); req = 1; we = 0; addr = a;
    @(negedge clk); req = 0; d = rdata;
  endtask

  task automatic settle(); @(negedge clk); endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 main_irq", {31'b0, mirq}, 0);
    chk("R1 dma_irq", {31'b0, dirq}, 0);
    chk("R1 flag_irq", {31'b0, firq}, 0);
    rd(16'hF000, v); chk("R1 main stat", v, 0);
    rd(16'hF010, v); chk("R1 main mask", v, 0);
    rd(16'hE010, v); chk("R1 dma word", v, 0);
    rd(16'hF230, v); chk("R1 flags", v, 0);
  endtask

  task automatic t_main();
    logic [31:0] v;
    @(negedge clk); msrc = 32'h0000_00A5;
    @(negedge clk); msrc = '0;
    rd(16'hF000, v); chk("R2 sticky", v, 32'hA5);
    chk("R5 masked off", {31'b0, mirq}, 0);
    wr(16'hF010, 32'h0000_0004);
    rd(16'hF010, v); chk("R4 mask read", v, 32'h4);
    chk("R5 enabled", {31'b0, mirq}, 1);
    wr(16'hF010, 32'h0000_0002);
    settle(); chk("R4 mask replaced", {31'b0, mirq}, 0);
    wr(16'hF010, 32'h0000_0021);
    wr(16'hF000, 32'h0000_0021);
    rd(16'hF000, v); chk("R3 partial clear", v, 32'h84);
    chk("R5 cleared drop", {31'b0, mirq}, 0);
    wr(16'hF000, 32'hFFFF_FFFF);
    rd(16'hF000, v); chk("R3 full clear", v, 0);
  endtask

  task automatic t_dma();
    logic [31:0] v;
    wr(16'hE020, 32'h0030_0000);
    @(negedge clk); dsrc = 16'h0011;
    @(negedge clk); dsrc = '0;
    rd(16'hE010, v); chk("R6 packed read", v, 32'h0030_0011);
    chk("R8 gated on", {31'b0, dirq}, 1);
    wr(16'hE010, 32'hFFFF_0010);
    rd(16'hE010, v); chk("R6 mask kept", v, 32'h0030_0001);
    chk("R8 gated off", {31'b0, dirq}, 0);
    wr(16'hE020, 32'h0001_FFFF);
    rd(16'hE010, v); chk("R7 mask load", v, 32'h0001_0001);
    chk("R8 new mask", {31'b0, dirq}, 1);
    wr(16'hE010, 32'h0000_0001);
    settle(); chk("R8 drop", {31'b0, dirq}, 0);
  endtask

  task automatic t_flag();
    logic [31:0] v;
    @(negedge clk); fsrc = 8'h03;
    @(negedge clk); fsrc = '0;
    settle(); chk("R9 raised", {31'b0, firq}, 1);
    wr(16'hF230, 32'h1);
    settle(); chk("R9 partial stays", {31'b0, firq}, 1);
    rd(16'hF230, v); chk("R9 flag read", v, 32'h2);
    wr(16'hF230, 32'h2);
    settle(); chk("R9 all zero", {31'b0, firq}, 0);
  endtask

  task automatic t_collision();
    logic [31:0] v;
    @(negedge clk); msrc = 32'h1;
    @(negedge clk); msrc = '0;
    @(negedge clk); req = 1; we = 1; addr = 16'hF000; wdata = 32'h3; msrc = 32'h2;
    @(negedge clk); req = 0; we = 0; wdata = '0; msrc = '0;
    rd(16'hF000, v); chk("R10 set wins", v, 32'h2);
    wr(16'hF000, 32'h2);
  endtask

  task automatic t_unmapped();
    logic [31:0] v;
    @(negedge clk); fsrc = 8'h40; dsrc = 16'h0100;
    @(negedge clk); fsrc = '0; dsrc = '0;
    wr(16'h1234, 32'hFFFF_FFFF);
    wr(16'hF004, 32'hFFFF_FFFF);
    rd(16'h1234, v); chk("R11 unmapped read", v, 0);
    rd(16'hF230, v); chk("R11 flags untouched", v, 32'h40);
    rd(16'hE010, v); chk("R11 dma untouched", v, 32'h0001_0100);
    rd(16'hF010, v); chk("R11 mask untouched", v, 32'h21);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle();
    t_reset();
    t_main();
    t_dma();
    t_flag();
    t_collision();
    t_unmapped();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule